// File: doc/BRIEF.md
# Step and Direction Pulse Generator

This block turns a programmable signed velocity into motor step pulses. A 48-bit position accumulator holds 16 bits of whole steps above 32 bits of fraction. Each time a shared master rate accumulator overflows, the block adds the signed 32-bit rate to the position. Whenever the whole-step field moves by one, the block records a step event. The direction of that event comes from the sign of the rate.

Step events go into a signed pending count and are never dropped. A pulse state machine drains that count one pulse at a time. It has four named states:

- `PS_READY` waits for work. It moves to `PS_SETUP` when the pending sign disagrees with the current direction and the hold timer has expired. It moves to `PS_ACTIVE` when the sign agrees.
- `PS_SETUP` counts out the direction setup time, then returns to `PS_READY`.
- `PS_ACTIVE` holds the pulse for its active width, then moves to `PS_GAP`.
- `PS_GAP` counts out the idle width, then returns to `PS_READY`.

An encoder maps the pulse, the direction and two step-tracking registers onto six output pins. It supports four formats: step/direction, up/down, two-phase quadrature, or a user-loaded sequence table. The host uses a one-cycle write strobe with a register select, and reads the position continuously as a 16.16 value.

Top module: `stepgen_core`

## Requirements
- R1: After reset all six pins are 0 and the position read-back is 0.
- R2: Writing select 0 sets the signed rate. On every cycle where the master accumulator (32 bits, adding `master_rate` each cycle) carries out, the rate is sign-extended and added to the 48-bit accumulator. `pos_rd` always shows accumulator bits 47:16.
- R3: Writing select 1 loads the data into accumulator bits 47:16 and clears bits 15:0. This write takes priority over an add in the same cycle and produces no step pulse.
- R4: With `master_rate` at 0 the position never changes. With `master_rate` at 2^31 an add happens every other cycle.
- R5: Each change of the whole-step field produces exactly one pulse. The pulse is forward when the rate is non-negative and reverse when it is negative, so the net count of pulses equals the net whole-step movement.
- R6: Select 2 sets the mode from data bits 1:0. In mode 0 (step/dir), pin 0 is the step pulse and pin 1 is the direction (1 = reverse), and pins 5:2 are 0.
- R7: In mode 1 (up/down), pin 0 pulses for forward steps and pin 1 pulses for reverse steps. The two pins are never high together.
- R8: In mode 2 (quadrature), a phase counter advances on forward steps and retreats on reverse steps. Phases 0, 1, 2, 3 drive {pin1, pin0} = 00, 01, 11, 10, so no more than one of the two pins changes per cycle.
- R9: Writing select 7 shifts data bits 5:0 into the table at entry 0, so the last word written becomes entry 0. Select 8 sets the length code L (4 bits, reset 15). In mode 3 the pins show the entry at an index that moves once per step, modulo L+1, starting from 0.
- R10: Select 5 sets the active width A and select 6 sets the idle width I (14 bits each). A pulse is high for exactly max(A,1) cycles, and the pin stays low for at least max(I,1) cycles between pulses.
- R11: Select 3 sets the setup time S (14 bits). A pulse begins no sooner than S cycles after the direction changes.
- R12: Select 4 sets the hold time H (14 bits). The direction changes no sooner than H cycles after a pulse ends, and never while a pulse is high.
- R13: Step events that arrive faster than pulses can be issued are queued with a signed pending count. Every one of them is issued later, with events of opposite direction cancelling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | One-cycle register write strobe |
| cfg_sel | input | 4 | Register select for the write |
| cfg_wdata | input | 32 | Write data |
| master_rate | input | 32 | Shared master rate increment |
| pos_rd | output | 32 | Position read-back, 16.16 whole.fraction |
| pins_o | output | 6 | Encoded output pins |

## Verification
The main function is exercised in several ways, and each one separates a different class of fault:

- Random positive and negative rates at random master rates, with random setup, hold, active and idle counts. These separate correct step counting and direction reversal from lost or duplicated steps, and they expose any timing rule broken at a direction change.
- A saturating burst at full rate. This shows whether pending steps are queued or lost.
- Runs with the master rate at zero and at one half. These separate gating faults from faults in the accumulator's sign extension.
- Runs in the quadrature and table modes in both directions, including a reverse walk below index 0. These expose errors in phase order, table load order and wrap length that step/dir runs cannot reveal.

// File: rtl/stepgen_pkg.sv
package stepgen_pkg;

    typedef enum logic [1:0] {
        ENC_STEPDIR = 2'd0,
        ENC_UPDOWN  = 2'd1,
        ENC_QUAD    = 2'd2,
        ENC_TABLE   = 2'd3
    } enc_mode_e;

    typedef enum logic [1:0] {
        PS_READY,
        PS_SETUP,
        PS_ACTIVE,
        PS_GAP
    } pulse_state_e;

    typedef enum logic [3:0] {
        SEL_RATE   = 4'd0,
        SEL_POS    = 4'd1,
        SEL_MODE   = 4'd2,
        SEL_SETUP  = 4'd3,
        SEL_HOLD   = 4'd4,
        SEL_ACTIVE = 4'd5,
        SEL_IDLE   = 4'd6,
        SEL_TPUSH  = 4'd7,
        SEL_TLEN   = 4'd8
    } cfg_sel_e;

endpackage

// File: rtl/stepgen_master_dds.sv
module stepgen_master_dds #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rate_i,
    output logic         tick_o
);
    logic [W-1:0] acc_q;
    logic [W-1:0] sum;

    assign {tick_o, sum} = {1'b0, acc_q} + {1'b0, rate_i};

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= sum;
    end
endmodule

// File: rtl/stepgen_accum.sv
module stepgen_accum #(
    parameter int FULL_W = 16,
    parameter int FRAC_W = 32,
    parameter int RATE_W = 32,
    parameter int RD_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              pos_wr_i,
    input  logic [RD_W-1:0]   pos_data_i,
    output logic [RD_W-1:0]   pos_o,
    output logic              evt_o,
    output logic              evt_dir_o
);
    localparam int ACC_W = FULL_W + FRAC_W;
    localparam int EXT_W = ACC_W - RATE_W;
    localparam int PAD_W = ACC_W - RD_W;

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  acc_sum;
    logic [FULL_W-1:0] whole;

    assign acc_sum   = acc_q + {{EXT_W{rate_i[RATE_W-1]}}, rate_i};
    assign whole     = acc_q[ACC_W-1 -: FULL_W];
    assign evt_o     = tick_i && !pos_wr_i && (acc_sum[ACC_W-1 -: FULL_W] != whole);
    assign evt_dir_o = rate_i[RATE_W-1];
    assign pos_o     = acc_q[ACC_W-1 -: RD_W];

    always_ff @(posedge clk) begin
        if (!rst_n)        acc_q <= '0;
        else if (pos_wr_i) acc_q <= {pos_data_i, {PAD_W{1'b0}}};
        else if (tick_i)   acc_q <= acc_sum;
    end

    AST_FWD_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o && !evt_dir_o |=> (whole - $past(whole)) == FULL_W'(1)); // R5
    AST_REV_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o && evt_dir_o |=> (whole - $past(whole)) == {FULL_W{1'b1}}); // R5
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && !pos_wr_i |=> $stable(acc_q)); // R4
endmodule

// File: rtl/stepgen_pulse_fsm.sv
module stepgen_pulse_fsm
    import stepgen_pkg::*;
#(
    parameter int TW     = 14,
    parameter int PEND_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt_i,
    input  logic          evt_dir_i,
    input  logic [TW-1:0] setup_i,
    input  logic [TW-1:0] hold_i,
    input  logic [TW-1:0] active_i,
    input  logic [TW-1:0] idle_i,
    output logic          step_o,
    output logic          dir_o,
    output logic          fire_o
);
    localparam logic signed [PEND_W-1:0] ONE   = PEND_W'(1);
    localparam logic signed [PEND_W-1:0] P_MAX = {1'b0, {(PEND_W-1){1'b1}}};
    localparam logic signed [PEND_W-1:0] P_MIN = {1'b1, {(PEND_W-1){1'b0}}};

    pulse_state_e             state_q, state_d;
    logic [TW-1:0]            tcnt_q, hold_q;
    logic signed [PEND_W-1:0] pend_q, pend_d;
    logic                     dir_q, flip, want_dir, tdone;

    assign want_dir = pend_q[PEND_W-1];
    assign tdone    = (tcnt_q <= TW'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_READY;
        else        state_q <= state_d;
    end

    // next state and strobes
    always_comb begin
        state_d = state_q;
        flip    = 1'b0;
        fire_o  = 1'b0;
        unique case (state_q)
            PS_READY: begin
                if (pend_q != '0) begin
                    if (want_dir != dir_q) begin
                        if (hold_q == '0) begin
                            state_d = PS_SETUP;
                            flip    = 1'b1;
                        end
                    end else begin
                        state_d = PS_ACTIVE;
                        fire_o  = 1'b1;
                    end
                end
            end
            PS_SETUP:  if (tdone) state_d = PS_READY;
            PS_ACTIVE: if (tdone) state_d = PS_GAP;
            PS_GAP:    if (tdone) state_d = PS_READY;
            default:   state_d = PS_READY;
        endcase
    end

    always_comb begin
        pend_d = pend_q;
        if (evt_i)  pend_d = evt_dir_i ? pend_d - ONE : pend_d + ONE;
        if (fire_o) pend_d = dir_q ? pend_d + ONE : pend_d - ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            hold_q <= '0;
            dir_q  <= 1'b0;
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
            if (flip) dir_q <= ~dir_q;
            if (state_d != state_q) begin
                unique case (state_d)
                    PS_SETUP:  tcnt_q <= setup_i;
                    PS_ACTIVE: tcnt_q <= active_i;
                    PS_GAP:    tcnt_q <= idle_i;
                    default:   tcnt_q <= '0;
                endcase
            end else if (tcnt_q != '0) begin
                tcnt_q <= tcnt_q - TW'(1);
            end
            if (state_q == PS_ACTIVE && state_d == PS_GAP) hold_q <= hold_i;
            else if (hold_q != '0)                         hold_q <= hold_q - TW'(1);
        end
    end

    assign step_o = (state_q == PS_ACTIVE);
    assign dir_o  = dir_q;

    AST_SETUP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q) == PS_SETUP |-> (state_q == PS_SETUP || state_q == PS_READY)); // R11
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dir_o) |-> ($past(hold_q) == '0 && !$past(step_o))); // R12
    AST_PEND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q != P_MAX && pend_q != P_MIN); // R13
    AST_FIRE_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> pend_q != '0); // R5
endmodule

// File: rtl/stepgen_encoder.sv
module stepgen_encoder
    import stepgen_pkg::*;
#(
    parameter int OUT_W = 6,
    parameter int TBL_N = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  enc_mode_e        mode_i,
    input  logic             step_i,
    input  logic             dir_i,
    input  logic             fire_i,
    input  logic             tbl_push_i,
    input  logic [OUT_W-1:0] tbl_data_i,
    input  logic [$clog2(TBL_N)-1:0] tbl_len_i,
    output logic [OUT_W-1:0] pins_o
);
    localparam int IDX_W = $clog2(TBL_N);

    logic [OUT_W-1:0] tbl_q [TBL_N];
    logic [IDX_W-1:0] idx_q;
    logic [1:0]       phase_q;

    for (genvar i = 0; i < TBL_N; i++) begin : g_tbl
        always_ff @(posedge clk) begin
            if (!rst_n)          tbl_q[i] <= '0;
            else if (tbl_push_i) tbl_q[i] <= (i == 0) ? tbl_data_i : tbl_q[(i == 0) ? 0 : i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            phase_q <= '0;
        end else if (fire_i) begin
            if (!dir_i) begin
                phase_q <= phase_q + 2'd1;
                idx_q   <= (idx_q >= tbl_len_i) ? '0 : idx_q + IDX_W'(1);
            end else begin
                phase_q <= phase_q - 2'd1;
                idx_q   <= (idx_q == '0 || idx_q > tbl_len_i) ? tbl_len_i : idx_q - IDX_W'(1);
            end
        end
    end

    always_comb begin
        pins_o = '0;
        unique case (mode_i)
            ENC_STEPDIR: begin
                pins_o[0] = step_i;
                pins_o[1] = dir_i;
            end
            ENC_UPDOWN: begin
                pins_o[0] = step_i & ~dir_i;
                pins_o[1] = step_i & dir_i;
            end
            ENC_QUAD: begin
                pins_o[0] = phase_q[1] ^ phase_q[0];
                pins_o[1] = phase_q[1];
            end
            ENC_TABLE: pins_o = tbl_q[idx_q];
            default:   pins_o = '0;
        endcase
    end

    AST_UPDOWN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == ENC_UPDOWN |-> !(pins_o[0] && pins_o[1])); // R7
    AST_QUAD_GRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == ENC_QUAD && $past(mode_i) == ENC_QUAD)
        |-> $countones(pins_o[1:0] ^ $past(pins_o[1:0])) <= 1); // R8
endmodule

// File: rtl/stepgen_core.sv
module stepgen_core
    import stepgen_pkg::*;
#(
    parameter int FULL_W = 16,
    parameter int FRAC_W = 32,
    parameter int DW     = 32,
    parameter int TW     = 14,
    parameter int PEND_W = 8,
    parameter int OUT_W  = 6,
    parameter int TBL_N  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_sel,
    input  logic [DW-1:0]    cfg_wdata,
    input  logic [DW-1:0]    master_rate,
    output logic [DW-1:0]    pos_rd,
    output logic [OUT_W-1:0] pins_o
);
    localparam int IDX_W = $clog2(TBL_N);

    logic [DW-1:0]    rate_q;
    enc_mode_e        mode_q;
    logic [TW-1:0]    setup_q, hold_q, act_q, idle_q;
    logic [IDX_W-1:0] tlen_q;
    logic             tick, evt, evt_dir, step, dir, fire;

    function automatic logic hit(input cfg_sel_e s);
        return cfg_we && (cfg_sel == s);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q  <= '0;
            mode_q  <= ENC_STEPDIR;
            setup_q <= '0;
            hold_q  <= '0;
            act_q   <= '0;
            idle_q  <= '0;
            tlen_q  <= '1;
        end else begin
            if (hit(SEL_RATE))   rate_q  <= cfg_wdata;
            if (hit(SEL_MODE))   mode_q  <= enc_mode_e'(cfg_wdata[1:0]);
            if (hit(SEL_SETUP))  setup_q <= cfg_wdata[TW-1:0];
            if (hit(SEL_HOLD))   hold_q  <= cfg_wdata[TW-1:0];
            if (hit(SEL_ACTIVE)) act_q   <= cfg_wdata[TW-1:0];
            if (hit(SEL_IDLE))   idle_q  <= cfg_wdata[TW-1:0];
            if (hit(SEL_TLEN))   tlen_q  <= cfg_wdata[IDX_W-1:0];
        end
    end

    stepgen_master_dds #(.W(DW)) u_dds (
        .clk(clk), .rst_n(rst_n), .rate_i(master_rate), .tick_o(tick)
    );

    stepgen_accum #(.FULL_W(FULL_W), .FRAC_W(FRAC_W), .RATE_W(DW), .RD_W(DW)) u_acc (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rate_i(rate_q),
        .pos_wr_i(hit(SEL_POS)), .pos_data_i(cfg_wdata), .pos_o(pos_rd),
        .evt_o(evt), .evt_dir_o(evt_dir)
    );

    stepgen_pulse_fsm #(.TW(TW), .PEND_W(PEND_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .evt_dir_i(evt_dir),
        .setup_i(setup_q), .hold_i(hold_q), .active_i(act_q), .idle_i(idle_q),
        .step_o(step), .dir_o(dir), .fire_o(fire)
    );

    stepgen_encoder #(.OUT_W(OUT_W), .TBL_N(TBL_N)) u_enc (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .step_i(step), .dir_i(dir),
        .fire_i(fire), .tbl_push_i(hit(SEL_TPUSH)), .tbl_data_i(cfg_wdata[OUT_W-1:0]),
        .tbl_len_i(tlen_q), .pins_o(pins_o)
    );

    AST_POS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        hit(SEL_POS) |=> pos_rd == $past(cfg_wdata)); // R3
endmodule

// File: tb/stepgen_core_tb.sv
`timescale 1ns/1ps
module stepgen_core_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [3:0]  cfg_sel = 0;
    logic [31:0] cfg_wdata = 0;
    logic [31:0] master_rate = 0;
    logic [31:0] pos_rd;
    logic [5:0]  pins_o;

    always #2 clk = ~clk;

    stepgen_core u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .master_rate(master_rate), .pos_rd(pos_rd), .pins_o(pins_o)
    );

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // reference model of the accumulator and step count
    logic [47:0] m_acc;
    logic [31:0] m_dds, m_rate;
    int          exp_net;
    always @(posedge clk) begin
        logic [32:0] d;
        logic [47:0] n;
        if (!rst_n) begin
            m_acc <= '0; m_dds <= '0; m_rate <= '0; exp_net <= 0;
        end else begin
            d = {1'b0, m_dds} + {1'b0, master_rate};
            m_dds <= d[31:0];
            if (cfg_we && cfg_sel == 4'd0) m_rate <= cfg_wdata;
            if (cfg_we && cfg_sel == 4'd1) m_acc <= {cfg_wdata, 16'h0};
            else if (d[32]) begin
                n = m_acc + {{16{m_rate[31]}}, m_rate};
                if (n[47:32] != m_acc[47:32]) exp_net <= exp_net + (m_rate[31] ? -1 : 1);
                m_acc <= n;
            end
        end
    end

    // pin monitor
    int  cur_mode = 0;
    bit  mon_on = 1;
    int  w_act = 0, w_idle = 0, w_setup = 0, w_hold = 0;
    int  hw = 0, lc = 1000, since_fall = 1000, since_dir = 1000;
    int  pulses_net = 0, ud_net = 0;
    int  viol_w = 0, viol_i = 0, viol_s = 0, viol_h = 0, viol_ud = 0, viol_q = 0;
    logic [1:0] pv = 0;

    function automatic int mx1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    always @(posedge clk) begin
        #1;
        if (rst_n && mon_on) begin
            if (cur_mode == 0) begin
                if (pins_o[1] != pv[1]) begin
                    if (pv[0] || pins_o[0]) viol_h++;
                    else if (since_fall - 1 < w_hold) viol_h++;
                    since_dir = 1;
                end else since_dir++;
                if (pins_o[0] && !pv[0]) begin
                    pulses_net += pins_o[1] ? -1 : 1;
                    if (lc < mx1(w_idle)) viol_i++;
                    if (since_dir - 1 < w_setup) viol_s++;
                    hw = 1;
                end else if (pins_o[0]) hw++;
                else if (pv[0]) begin
                    if (hw != mx1(w_act)) viol_w++;
                    lc = 1; since_fall = 1;
                end else begin
                    lc++; since_fall++;
                end
            end else if (cur_mode == 1) begin
                if (pins_o[0] && !pv[0]) ud_net++;
                if (pins_o[1] && !pv[1]) ud_net--;
                if (pins_o[0] && pins_o[1]) viol_ud++;
            end else if (cur_mode == 2) begin
                if (((pins_o[1:0] ^ pv) == 2'b11)) viol_q++;
            end
        end
        pv = pins_o[1:0];
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_times(input int a, input int i, input int s, input int h);
        wr(4'd5, a); wr(4'd6, i); wr(4'd3, s); wr(4'd4, h);
        w_act = a; w_idle = i; w_setup = s; w_hold = h;
    endtask

    task automatic set_mode(input int m);
        mon_on = 0;
        wr(4'd2, m);
        cur_mode = m;
        run(2);
        lc = 1000; since_fall = 1000; since_dir = 1000;
        mon_on = 1;
    endtask

    function automatic logic [5:0] tv(input int i);
        return 6'((i * 11 + 5) & 63);
    endfunction

    function automatic logic [1:0] gray(input int net);
        int p;
        p = ((net % 4) + 4) % 4;
        case (p)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    function automatic int mod6(input int net);
        return ((net % 6) + 6) % 6;
    endfunction

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int e0, p0;
        logic [31:0] r;
        void'($urandom(32'd20240611));
        run(4);
        rst_n = 1;
        run(1);
        chk(pins_o == 6'h0, "R1 pins", pins_o, 0);
        chk(pos_rd == 32'h0, "R1 pos", pos_rd, 0);

        // table load: length code 5, entries written last first
        wr(4'd8, 32'd5);
        for (int i = 5; i >= 0; i--) wr(4'd7, {26'h0, tv(i)});

        // master gating
        wr(4'd0, 32'h0100_0000);
        run(200);
        chk(pos_rd == 32'h0 && pos_rd == m_acc[47:16], "R4 zero master", pos_rd, 0);
        master_rate = 32'h8000_0000;
        run(300);
        chk(pos_rd == m_acc[47:16] && pos_rd != 0, "R4 half master", pos_rd, m_acc[47:16]);
        wr(4'd0, 32'h0);

        // position write, no pulses
        master_rate = 32'hFFFF_FFFF;
        e0 = exp_net; p0 = pulses_net;
        wr(4'd1, 32'h0012_8000);
        run(50);
        chk(pos_rd == 32'h0012_8000, "R3 load", pos_rd, 32'h0012_8000);
        chk(pulses_net == p0 && exp_net == e0, "R3 no pulse", pulses_net - p0, 0);

        // reverse run in step/dir mode
        set_times(3, 2, 4, 4);
        e0 = exp_net; p0 = pulses_net;
        wr(4'd0, ~32'h0100_0000 + 1);
        run(1200);
        wr(4'd0, 32'h0);
        run(300);
        chk(pins_o[1] == 1'b1 && pins_o[0] == 1'b0 && pins_o[5:2] == 0, "R6 stepdir pins", pins_o, 6'h2);
        chk(pulses_net - p0 == exp_net - e0 && exp_net != e0, "R5 reverse count",
            pulses_net - p0, exp_net - e0);
        chk(pos_rd == m_acc[47:16], "R2 pos reverse", pos_rd, m_acc[47:16]);

        // burst faster than pulses
        set_times(6, 6, 2, 2);
        e0 = exp_net; p0 = pulses_net;
        wr(4'd0, 32'h7FFF_FFFF);
        run(60);
        wr(4'd0, 32'h0);
        run(1500);
        chk(pulses_net - p0 == exp_net - e0 && exp_net - e0 > 15, "R13 burst",
            pulses_net - p0, exp_net - e0);

        // random runs in step/dir mode
        for (int k = 0; k < 4; k++) begin
            set_times($urandom_range(15, 0), $urandom_range(15, 0),
                      $urandom_range(15, 0), $urandom_range(15, 0));
            master_rate = $urandom | 32'h4000_0000;
            r = $urandom_range(32'h0200_0000, 32'h0080_0000);
            e0 = exp_net; p0 = pulses_net;
            wr(4'd0, r);
            run(3000);
            wr(4'd0, ~r + 1);
            run(3000);
            wr(4'd0, 32'h0);
            run(1500);
            chk(pulses_net - p0 == exp_net - e0, "R5 random count", pulses_net - p0, exp_net - e0);
            chk(pos_rd == m_acc[47:16], "R2 random pos", pos_rd, m_acc[47:16]);
            chk(viol_w == 0, "R10 active width", viol_w, 0);
            chk(viol_i == 0, "R10 idle width", viol_i, 0);
            chk(viol_s == 0, "R11 setup", viol_s, 0);
            chk(viol_h == 0, "R12 hold", viol_h, 0);
        end

        // up/down
        set_times(2, 3, 1, 1);
        master_rate = 32'hFFFF_FFFF;
        set_mode(1);
        e0 = exp_net; p0 = ud_net;
        wr(4'd0, 32'h0100_0000);
        run(3000);
        wr(4'd0, ~32'h0180_0000 + 1);
        run(2000);
        wr(4'd0, 32'h0);
        run(500);
        chk(ud_net - p0 == exp_net - e0, "R7 up/down net", ud_net - p0, exp_net - e0);
        chk(viol_ud == 0, "R7 exclusive", viol_ud, 0);

        // quadrature
        set_mode(2);
        chk(pins_o[1:0] == gray(exp_net) && pins_o[5:2] == 0, "R8 quad entry", pins_o, gray(exp_net));
        wr(4'd0, 32'h0100_0000);
        run(2500);
        wr(4'd0, 32'h0);
        run(300);
        chk(pins_o[1:0] == gray(exp_net), "R8 quad fwd", pins_o[1:0], gray(exp_net));
        wr(4'd0, ~32'h0140_0000 + 1);
        run(2000);
        wr(4'd0, 32'h0);
        run(300);
        chk(pins_o[1:0] == gray(exp_net), "R8 quad rev", pins_o[1:0], gray(exp_net));
        chk(viol_q == 0, "R8 gray order", viol_q, 0);

        // table mode
        set_mode(3);
        chk(pins_o == tv(mod6(exp_net)), "R9 table entry", pins_o, tv(mod6(exp_net)));
        wr(4'd0, ~32'h0200_0000 + 1);
        run(1500);
        wr(4'd0, 32'h0);
        run(300);
        chk(pins_o == tv(mod6(exp_net)), "R9 table rev", pins_o, tv(mod6(exp_net)));
        wr(4'd0, 32'h0180_0000);
        run(1700);
        wr(4'd0, 32'h0);
        run(300);
        chk(pins_o == tv(mod6(exp_net)), "R9 table fwd", pins_o, tv(mod6(exp_net)));
        chk(pos_rd == m_acc[47:16], "R2 final pos", pos_rd, m_acc[47:16]);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule